// File: doc/BRIEF.md
# Shift-Coded Six-Bit Character Encoder

This block turns a stream of 7-bit ASCII bytes into a stream of 6-bit codes drawn from a 64-entry set. The set has no separate lowercase letters. Capital and small letters share one group of codes. The active case is selected by two locking shift codes, and the block keeps track of which case the receiver is in. It emits a shift only when a letter needs the other case. Control characters, and bytes whose natural slot is reserved or missing, go out as a one-shot escape code followed by a code from the escape page. The delete byte becomes the fill code.

Bytes arrive on a valid/ready input, and codes leave on a valid/ready output. The output valid follows the input valid combinationally, so no storage sits at either edge. When a byte needs a prefix (a shift or the escape), the prefix is offered first. The byte is accepted only in the cycle its own code is taken. After reset the receiver's case is treated as unknown, so the first letter always carries a shift.

Top module: `sixbit_shift_encoder`

## Requirements
- R1: After reset the case state is unknown, so the first letter of either case is preceded by a shift code, and out_valid is 0 while in_valid is 0.
- R2: A capital A..Z (0x41..0x5A) gives code byte-0x20 (0x21..0x3A). It is preceded by the upper shift 0x3C unless the case is already upper. Once that shift is taken, the case is upper.
- R3: A small a..z (0x61..0x7A) gives the same code as its capital (byte-0x40). It is preceded by the lower shift 0x3D unless the case is already lower. Once that shift is taken, the case is lower.
- R4: Shifts lock: a letter whose case matches the current state is sent as its code alone, with no shift.
- R5: The bytes 0x20..0x5B that are not letters give the single code byte-0x20 and leave the case state unchanged.
- R6: A control byte 0x00..0x1F gives the escape code 0x3E followed by the byte value. The escape leaves the case state unchanged.
- R7: Punctuation substitutions: '$' gives the single code 0x04 (the pound glyph). '\' gives 0x3E,0x3C (dollar). '^' gives 0x3E,0x3E (up arrow). '_' gives 0x3E,0x3F (left arrow). '`' gives 0x3E,0x24 (underscore). The other escaped bytes are ']' → 0x3E,0x3D and 0x7B..0x7E → 0x3E followed by byte-0x5B.
- R8: The delete byte 0x7F gives the single fill code 0x3F and leaves the case state unchanged.
- R9: When a prefix is emitted, in_ready stays 0 during the prefix transfer. The byte is accepted in the same cycle that its own code is transferred.
- R10: While out_ready is 0, in_ready is 0, nothing is consumed and the offered code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | ASCII byte offered |
| in_ready | output | 1 | ASCII byte accepted this cycle |
| in_char | input | 7 | ASCII byte |
| out_valid | output | 1 | Code offered |
| out_ready | input | 1 | Sink takes the code this cycle |
| out_code | output | 6 | 6-bit code |

## Verification
The hardest condition to set up is a byte whose expected output depends on a case state left behind by earlier traffic. Examples are a letter after a run of escapes, or a non-letter sitting between two letters of the same case. The sweep puts the encoder into each of the three case states: unknown by reset, upper by sending a capital, lower by sending a small letter. It then sends every one of the 128 byte values, followed by a probe letter that shows whether the state survived. Every fifth byte is stalled for one cycle with out_ready low, to check that the offered code holds during a prefix as well as during the character.

// File: rtl/sse_pkg.sv
// Package: shared types and code constants for the shift-coded encoder.
// Assumes a 6-bit code set whose top four codes are reserved for control.
package sse_pkg;
    localparam int CODE_W = 6;
    localparam int CHAR_W = 7;
    localparam logic [CODE_W-1:0] CODE_FILL  = CODE_W'((1 << CODE_W) - 1);
    localparam logic [CODE_W-1:0] CODE_ESC   = CODE_W'((1 << CODE_W) - 2);
    localparam logic [CODE_W-1:0] CODE_LOWER = CODE_W'((1 << CODE_W) - 3);
    localparam logic [CODE_W-1:0] CODE_UPPER = CODE_W'((1 << CODE_W) - 4);

    typedef enum logic [1:0] {CASE_NONE, CASE_UP, CASE_LO} case_t;
    typedef enum logic [2:0] {K_DIRECT, K_UPPER, K_LOWER, K_ESCAPED, K_FILL} kind_t;
endpackage

// File: rtl/sse_classify.sv
// Module: sse_classify
// Purely combinational. Sorts one ASCII byte into a kind and gives its base
// code: the code sent after any prefix. Assumes 7-bit input and 6-bit codes.
module sse_classify
    import sse_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output kind_t             kind,
    output logic [CODE_W-1:0] code
);
    localparam logic [CHAR_W-1:0] SPACE = CHAR_W'(8'h20);

    logic [CHAR_W-1:0] diff;

    // Purpose: decode byte ranges into kind and base code.
    always_comb begin
        kind = K_DIRECT;
        diff = ch - SPACE;
        if (ch < 7'h20) begin
            kind = K_ESCAPED;
            diff = ch;
        end else if (ch <= 7'h5B) begin
            kind = (ch >= 7'h41 && ch <= 7'h5A) ? K_UPPER : K_DIRECT;
        end else if (ch <= 7'h5F) begin
            kind = K_ESCAPED;
        end else if (ch == 7'h60) begin
            kind = K_ESCAPED;
            diff = 7'h24;
        end else if (ch <= 7'h7A) begin
            kind = K_LOWER;
            diff = ch - 7'h40;
        end else if (ch <= 7'h7E) begin
            kind = K_ESCAPED;
            diff = ch - 7'h5B;
        end else begin
            kind = K_FILL;
            diff = CHAR_W'(CODE_FILL);
        end
        code = diff[CODE_W-1:0];
    end
endmodule

// File: rtl/sse_case_track.sv
// Module: sse_case_track
// Holds the receiver's current letter case. Reset makes it unknown. A
// transferred shift code locks the case it selects.
module sse_case_track
    import sse_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_up,
    input  logic  set_lo,
    output case_t state
);
    // Purpose: update the case state when a shift code is transferred.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= CASE_NONE;
        else if (set_up) state <= CASE_UP;
        else if (set_lo) state <= CASE_LO;
    end
endmodule

// File: rtl/sse_sequencer.sv
// Module: sse_sequencer
// Decides whether a byte needs a prefix and steps through prefix then
// character. Assumes the source holds in_char steady while in_valid is
// high and the byte has not yet been accepted.
module sse_sequencer
    import sse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    input  kind_t             kind,
    input  logic [CODE_W-1:0] code,
    input  case_t             case_st,
    output logic              in_ready,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic              set_up,
    output logic              set_lo
);
    logic              pre_sent;
    logic              need_pre;
    logic              char_phase;
    logic              fire;
    logic [CODE_W-1:0] prefix;

    // Purpose: work out the prefix need and drive the output side.
    always_comb begin
        unique case (kind)
            K_ESCAPED: need_pre = 1'b1;
            K_UPPER:   need_pre = (case_st != CASE_UP);
            K_LOWER:   need_pre = (case_st != CASE_LO);
            default:   need_pre = 1'b0;
        endcase
        prefix     = (kind == K_ESCAPED) ? CODE_ESC :
                     (kind == K_UPPER)   ? CODE_UPPER : CODE_LOWER;
        char_phase = !need_pre || pre_sent;
        out_valid  = in_valid;
        out_code   = char_phase ? code : prefix;
        in_ready   = out_ready && char_phase;
        fire       = in_valid && out_ready;
        set_up     = fire && !char_phase && (kind == K_UPPER);
        set_lo     = fire && !char_phase && (kind == K_LOWER);
    end

    // Purpose: remember that a prefix went out for the byte still held.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pre_sent <= 1'b0;
        else if (fire && char_phase)  pre_sent <= 1'b0;
        else if (fire)                pre_sent <= 1'b1;
    end
endmodule

// File: rtl/sixbit_shift_encoder.sv
// Module: sixbit_shift_encoder
// Top level: ASCII bytes in, shift-coded 6-bit codes out, valid/ready on
// both sides with no storage at the edges. The widths are fixed by the
// code set and carried as parameters for documentation.
module sixbit_shift_encoder
    import sse_pkg::*;
#(
    parameter int IN_W  = CHAR_W,
    parameter int OUT_W = CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_char,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_code
);
    kind_t             kind;
    logic [CODE_W-1:0] base_code;
    case_t             case_q;
    logic              set_up;
    logic              set_lo;

    sse_classify u_cls (
        .ch   (CHAR_W'(in_char)),
        .kind (kind),
        .code (base_code)
    );

    sse_case_track u_case (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_up (set_up),
        .set_lo (set_lo),
        .state  (case_q)
    );

    logic [CODE_W-1:0] seq_code;

    sse_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .kind      (kind),
        .code      (base_code),
        .case_st   (case_q),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_code  (seq_code),
        .set_up    (set_up),
        .set_lo    (set_lo)
    );

    assign out_code = OUT_W'(seq_code);
endmodule

// File: rtl/sse_checker.sv
// Module: sse_checker
// Temporal checks on the encoder's handshake and case tracking. It is
// attached to every instance of the top through the bind below.
module sse_checker
    import sse_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CODE_W-1:0] out_code,
    input logic [1:0]        case_st
);
    logic pre_fire;
    assign pre_fire = out_valid && out_ready && !in_ready;

    AST_ACCEPT_WITH_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready)); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10
    AST_UP_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && out_code == CODE_UPPER) |-> (case_st != 2'(CASE_UP))); // R4
    AST_LO_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && out_code == CODE_LOWER) |-> (case_st != 2'(CASE_LO))); // R4
    AST_UP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && out_code == CODE_UPPER) |=> (case_st == 2'(CASE_UP))); // R2
    AST_LO_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && out_code == CODE_LOWER) |=> (case_st == 2'(CASE_LO))); // R3
    AST_ESC_KEEPS_CASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && out_code == CODE_ESC) |=> $stable(case_st)); // R6
    AST_CASE_NEVER_FORGOTTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (case_st != 2'(CASE_NONE)) |=> (case_st != 2'(CASE_NONE))); // R1
endmodule

bind sixbit_shift_encoder sse_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .case_st   (case_q)
);

// File: tb/sim_sixbit_shift_encoder.sv
module sim_sixbit_shift_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [6:0] in_char = 7'h0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [5:0] out_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int mcase = 0; // 0 unknown, 1 upper, 2 lower

    always #2 clk = ~clk;

    sixbit_shift_encoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_char(in_char), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; out_ready = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        mcase = 0;
        #1 chk("R1", "out_valid idle", int'(out_valid), 0);
    endtask

    // Computes the expected codes from the requirements and drives one byte.
    task automatic send(input logic [6:0] c, input bit stall);
        int  pre;
        int  code;
        bit  has_pre;
        string req;
        int  v = int'(c);
        has_pre = 0; pre = 0;
        if (v >= 'h41 && v <= 'h5A) begin
            code = v - 'h20;
            req = (mcase == 0) ? "R1" : (mcase == 1 ? "R4" : "R2");
            if (mcase != 1) begin has_pre = 1; pre = 'h3C; end
            mcase = 1;
        end else if (v >= 'h61 && v <= 'h7A) begin
            code = v - 'h40;
            req = (mcase == 0) ? "R1" : (mcase == 2 ? "R4" : "R3");
            if (mcase != 2) begin has_pre = 1; pre = 'h3D; end
            mcase = 2;
        end else if (v < 'h20) begin
            has_pre = 1; pre = 'h3E; code = v; req = "R6";
        end else if (v == 'h24) begin
            code = 'h04; req = "R7";
        end else if (v >= 'h5C && v <= 'h5F) begin
            has_pre = 1; pre = 'h3E; code = v - 'h20; req = "R7";
        end else if (v == 'h60) begin
            has_pre = 1; pre = 'h3E; code = 'h24; req = "R7";
        end else if (v >= 'h7B && v <= 'h7E) begin
            has_pre = 1; pre = 'h3E; code = v - 'h5B; req = "R7";
        end else if (v == 'h7F) begin
            code = 'h3F; req = "R8";
        end else begin
            code = v - 'h20; req = "R5";
        end
        in_char = c; in_valid = 1;
        if (stall) begin
            out_ready = 0;
            #1;
            chk("R10", "stall in_ready", int'(in_ready), 0);
            chk("R10", "stall code", int'(out_code), has_pre ? pre : code);
            @(negedge clk);
            #1 chk("R10", "stall code held", int'(out_code), has_pre ? pre : code);
        end
        out_ready = 1;
        if (has_pre) begin
            #1;
            chk(req, "prefix code", int'(out_code), pre);
            chk("R9", "ready during prefix", int'(in_ready), 0);
            @(negedge clk);
        end
        #1;
        chk(req, "char code", int'(out_code), code);
        chk("R9", "ready with char", int'(in_ready), 1);
        chk(req, "out_valid", int'(out_valid), 1);
        @(negedge clk);
        in_valid = 0; out_ready = 0;
    endtask

    initial begin
        do_reset();
        // Mixed-case words with a space and punctuation.
        send(7'h48, 0); send(7'h65, 0); send(7'h6C, 1); send(7'h6C, 0); send(7'h6F, 0);
        send(7'h20, 0); send(7'h57, 0); send(7'h6F, 0); send(7'h2C, 1); send(7'h72, 0);
        // Sweep every byte from every case state, then probe the state.
        for (int st = 0; st < 3; st++) begin
            for (int c = 0; c < 128; c++) begin
                if (st == 0) do_reset();
                else if (st == 1) send(7'h42, 0);
                else send(7'h62, 0);
                send(7'(c), (c % 5) == 0);
                send((st == 2) ? 7'h63 : 7'h43, 0);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule